// File: doc/BRIEF.md
# DRAM Sub-Row Activation Checker

This block sits on the controller side of a DRAM interface and watches the decoded command stream. It tracks, for every bank, whether the open row was sensed across its whole width or only in part. When a column access would read or write sense amplifiers that never received row data, the block flags it. It also holds the configuration that sets the device data width and the sub-row sensing fraction, and it refuses any pairing of the two that would leave part of a row unloaded.

A row activate opens its bank in full or partial mode, depending on the sub-row field in force at that moment. Refresh activates, whether they address all banks or one bank, always open rows in full. This also covers refreshes issued as the device leaves powerdown. When a bank is opened in partial mode, the block stores row-address bit 1. Each later column command to that bank must present the same value in column-address bit 1. A column command to a bank with no open row raises a separate flag. Both flags are registered pulses and carry the bank index.

Top module: `subrow_guard`

## Requirements
- R1: After a synchronous reset, the configuration reads width 001 (x2) and sub-row 00 (full), the config-error flag is low, every bank is idle, and both violation pulses are low.
- R2: A configuration write with a legal pair updates `cfg_width_q` and `cfg_sub_q` one cycle later. Width codes: 001=x2, 010=x4, 011=x8, 100=x16. Sub-row codes: 00=full, 01=half, 10=quarter. Sub-row 00 is legal with every known width. Codes 01 and 10 are legal only with 001.
- R3: A configuration write with an illegal pair is refused. This includes an unknown width code (000, 101, 110, 111) and sub-row code 11. The stored configuration keeps its old value, and `cfg_err` goes high and stays high until reset.
- R4: A row activate issued while sub-row is 00 opens the bank in full mode. A column command to a bank open in full mode never raises a violation.
- R5: A row activate issued while sub-row is 01 opens the bank in half mode and stores `act_sr1`. A later column command to that bank with `col_sc1` different from the stored bit raises `sub_viol_valid` one cycle after the command, with `viol_bank` set to the column's bank.
- R6: A row activate issued while sub-row is 10 (quarter) behaves exactly like sub-row 01.
- R7: A refresh activate opens its target in full mode whatever the sub-row field holds. With `ref_all` high the target is every bank; otherwise it is `ref_bank`.
- R8: A precharge returns the bank in `pre_bank` to idle, or every bank when `pre_all` is high.
- R9: A column command to an idle bank raises `no_row_valid` one cycle after the command, with `viol_bank` set to the column's bank.
- R10: Each violation pulse lasts one cycle per offending column command. The two pulses are never high together. `viol_bank` changes only when a column command is seen.
- R11: A column command is checked against the bank state from before any update in the same cycle. Within one cycle a precharge overrides an activate or a refresh to the same bank. A configuration write affects only activates in later cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_width | input | 3 | Width code to write |
| cfg_sub | input | 2 | Sub-row code to write |
| act_en | input | 1 | Row activate command |
| act_bank | input | BANK_W | Bank of the row activate |
| act_sr1 | input | 1 | Row-address bit 1 of the activate |
| ref_en | input | 1 | Refresh activate command |
| ref_all | input | 1 | Refresh targets all banks |
| ref_bank | input | BANK_W | Bank of a single-bank refresh |
| col_en | input | 1 | Column read/write command |
| col_bank | input | BANK_W | Bank of the column command |
| col_sc1 | input | 1 | Column-address bit 1 |
| pre_en | input | 1 | Precharge command |
| pre_all | input | 1 | Precharge targets all banks |
| pre_bank | input | BANK_W | Bank of a single-bank precharge |
| cfg_width_q | output | 3 | Stored width code |
| cfg_sub_q | output | 2 | Stored sub-row code |
| cfg_err | output | 1 | Sticky refused-write flag |
| sub_viol_valid | output | 1 | Pulse: partial-row bit mismatch |
| no_row_valid | output | 1 | Pulse: column to idle bank |
| viol_bank | output | BANK_W | Bank of the last column command |

## Verification
The hardest situation to reach is a refused configuration write that arrives after a legal partial-row setting is already in force. For that case the bench must show two things. First, banks opened after the refusal still open in half mode. Second, the sticky flag survives later legal writes. The stimulus sweeps all 32 width/sub-row pairs in sequence, so every refusal lands on top of a different earlier accepted value. The bench also drives same-cycle command collisions (activate with precharge, column with activate) to the same bank. Only those collisions show the ordering in R11.

// File: rtl/subrow_pkg.sv
package subrow_pkg;

  localparam logic [2:0] WID_X2  = 3'b001;
  localparam logic [2:0] WID_X4  = 3'b010;
  localparam logic [2:0] WID_X8  = 3'b011;
  localparam logic [2:0] WID_X16 = 3'b100;

  localparam logic [1:0] SUB_FULL = 2'b00;
  localparam logic [1:0] SUB_HALF = 2'b01;
  localparam logic [1:0] SUB_QTR  = 2'b10;

  typedef enum logic [1:0] {
    MODE_IDLE = 2'd0,
    MODE_FULL = 2'd1,
    MODE_HALF = 2'd2
  } bank_mode_e;

  typedef struct packed {
    bank_mode_e mode;
    logic       sr1;
  } bank_ent_t;

  function automatic logic width_known(input logic [2:0] w);
    return (w == WID_X2) || (w == WID_X4) || (w == WID_X8) || (w == WID_X16);
  endfunction

  // Partial sensing only at the narrowest width; quarter is taken as half.
  function automatic logic pair_legal(input logic [2:0] w, input logic [1:0] s);
    if (!width_known(w))              return 1'b0;
    if (s == SUB_FULL)                return 1'b1;
    if (s == SUB_HALF || s == SUB_QTR) return (w == WID_X2);
    return 1'b0;
  endfunction

endpackage

// File: rtl/subrow_cfg_reg.sv
module subrow_cfg_reg
  import subrow_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_en,
  input  logic [2:0] wr_width,
  input  logic [1:0] wr_sub,
  output logic [2:0] width_q,
  output logic [1:0] sub_q,
  output logic       err_q,
  output logic       half_mode
);

  logic accept;

  always_comb accept = pair_legal(wr_width, wr_sub);

  always_ff @(posedge clk) begin
    if (rst) begin
      width_q <= WID_X2;
      sub_q   <= SUB_FULL;
      err_q   <= 1'b0;
    end else if (wr_en) begin
      if (accept) begin
        width_q <= wr_width;
        sub_q   <= wr_sub;
      end else begin
        err_q <= 1'b1;
      end
    end
  end

  // Any stored non-full setting (half or quarter) senses half a row.
  always_comb half_mode = (sub_q != SUB_FULL);

endmodule

// File: rtl/subrow_bank_table.sv
module subrow_bank_table
  import subrow_pkg::*;
#(
  parameter int BANKS  = 8,
  parameter int BANK_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              half_mode,
  input  logic              act_en,
  input  logic [BANK_W-1:0] act_bank,
  input  logic              act_sr1,
  input  logic              ref_en,
  input  logic              ref_all,
  input  logic [BANK_W-1:0] ref_bank,
  input  logic              pre_en,
  input  logic              pre_all,
  input  logic [BANK_W-1:0] pre_bank,
  input  logic [BANK_W-1:0] rd_bank,
  output bank_ent_t         rd_ent
);

  bank_ent_t [BANKS-1:0] tbl;

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    localparam logic [BANK_W-1:0] IDX = BANK_W'(b);
    bank_ent_t ent_q;
    bank_ent_t ent_d;
    logic      hit_ref;
    logic      hit_act;
    logic      hit_pre;

    always_comb begin
      hit_ref = ref_en && (ref_all || ref_bank == IDX);
      hit_act = act_en && (act_bank == IDX);
      hit_pre = pre_en && (pre_all || pre_bank == IDX);
      ent_d   = ent_q;
      if (hit_ref) begin
        ent_d.mode = MODE_FULL;
        ent_d.sr1  = 1'b0;
      end
      if (hit_act) begin
        ent_d.mode = half_mode ? MODE_HALF : MODE_FULL;
        ent_d.sr1  = act_sr1;
      end
      if (hit_pre) begin
        ent_d.mode = MODE_IDLE;
        ent_d.sr1  = 1'b0;
      end
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        ent_q.mode <= MODE_IDLE;
        ent_q.sr1  <= 1'b0;
      end else begin
        ent_q <= ent_d;
      end
    end

    assign tbl[b] = ent_q;
  end

  always_comb rd_ent = tbl[rd_bank];

endmodule

// File: rtl/subrow_col_check.sv
module subrow_col_check
  import subrow_pkg::*;
#(
  parameter int BANK_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              col_en,
  input  logic [BANK_W-1:0] col_bank,
  input  logic              col_sc1,
  input  bank_ent_t         ent,
  output logic              sub_viol_q,
  output logic              no_row_q,
  output logic [BANK_W-1:0] bank_q
);

  logic mismatch;
  logic idle;

  always_comb begin
    idle     = (ent.mode == MODE_IDLE);
    mismatch = (ent.mode == MODE_HALF) && (ent.sr1 != col_sc1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sub_viol_q <= 1'b0;
      no_row_q   <= 1'b0;
      bank_q     <= '0;
    end else begin
      sub_viol_q <= col_en && mismatch;
      no_row_q   <= col_en && idle;
      if (col_en) bank_q <= col_bank;
    end
  end

endmodule

// File: rtl/subrow_guard.sv
module subrow_guard
  import subrow_pkg::*;
#(
  parameter  int BANKS  = 8,
  localparam int BANK_W = (BANKS > 1) ? $clog2(BANKS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_wr_en,
  input  logic [2:0]        cfg_width,
  input  logic [1:0]        cfg_sub,
  input  logic              act_en,
  input  logic [BANK_W-1:0] act_bank,
  input  logic              act_sr1,
  input  logic              ref_en,
  input  logic              ref_all,
  input  logic [BANK_W-1:0] ref_bank,
  input  logic              col_en,
  input  logic [BANK_W-1:0] col_bank,
  input  logic              col_sc1,
  input  logic              pre_en,
  input  logic              pre_all,
  input  logic [BANK_W-1:0] pre_bank,
  output logic [2:0]        cfg_width_q,
  output logic [1:0]        cfg_sub_q,
  output logic              cfg_err,
  output logic              sub_viol_valid,
  output logic              no_row_valid,
  output logic [BANK_W-1:0] viol_bank
);

  logic      half_mode;
  bank_ent_t col_ent;

  subrow_cfg_reg u_cfg (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (cfg_wr_en),
    .wr_width  (cfg_width),
    .wr_sub    (cfg_sub),
    .width_q   (cfg_width_q),
    .sub_q     (cfg_sub_q),
    .err_q     (cfg_err),
    .half_mode (half_mode)
  );

  subrow_bank_table #(.BANKS(BANKS), .BANK_W(BANK_W)) u_tbl (
    .clk       (clk),
    .rst       (rst),
    .half_mode (half_mode),
    .act_en    (act_en),
    .act_bank  (act_bank),
    .act_sr1   (act_sr1),
    .ref_en    (ref_en),
    .ref_all   (ref_all),
    .ref_bank  (ref_bank),
    .pre_en    (pre_en),
    .pre_all   (pre_all),
    .pre_bank  (pre_bank),
    .rd_bank   (col_bank),
    .rd_ent    (col_ent)
  );

  subrow_col_check #(.BANK_W(BANK_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .col_en     (col_en),
    .col_bank   (col_bank),
    .col_sc1    (col_sc1),
    .ent        (col_ent),
    .sub_viol_q (sub_viol_valid),
    .no_row_q   (no_row_valid),
    .bank_q     (viol_bank)
  );

endmodule

// File: rtl/subrow_guard_sva.sv
module subrow_guard_sva
  import subrow_pkg::*;
#(
  parameter int BANK_W = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              cfg_wr_en,
  input logic              act_en,
  input logic [BANK_W-1:0] act_bank,
  input logic              act_sr1,
  input logic              ref_en,
  input logic              col_en,
  input logic [BANK_W-1:0] col_bank,
  input logic              col_sc1,
  input logic              pre_en,
  input logic              pre_all,
  input logic [2:0]        cfg_width_q,
  input logic [1:0]        cfg_sub_q,
  input logic              cfg_err,
  input logic              sub_viol_valid,
  input logic              no_row_valid,
  input logic [BANK_W-1:0] viol_bank
);

  assert_cfg_always_legal_R2: assert property (@(posedge clk) disable iff (rst)
    pair_legal(cfg_width_q, cfg_sub_q));

  assert_cfg_held_R3: assert property (@(posedge clk) disable iff (rst)
    !cfg_wr_en |=> $stable({cfg_width_q, cfg_sub_q}));

  assert_err_sticky_R3: assert property (@(posedge clk) disable iff (rst)
    cfg_err |=> cfg_err);

  assert_pulses_exclusive_R10: assert property (@(posedge clk) disable iff (rst)
    !(sub_viol_valid && no_row_valid));

  assert_pulse_needs_col_R10: assert property (@(posedge clk) disable iff (rst)
    !col_en |=> (!sub_viol_valid && !no_row_valid && $stable(viol_bank)));

  assert_bank_reported_R9: assert property (@(posedge clk) disable iff (rst)
    col_en |=> (viol_bank == $past(col_bank)));

  assert_idle_after_pre_all_R8: assert property (@(posedge clk) disable iff (rst)
    (col_en && !$past(rst) && $past(pre_en) && $past(pre_all)) |=> no_row_valid);

  assert_half_mismatch_R5: assert property (@(posedge clk) disable iff (rst)
    (col_en && !$past(rst) && $past(act_en) && !$past(pre_en) && !$past(ref_en)
     && ($past(cfg_sub_q) != SUB_FULL) && (col_bank == $past(act_bank))
     && (col_sc1 != $past(act_sr1))) |=> sub_viol_valid);

endmodule

bind subrow_guard subrow_guard_sva #(.BANK_W(BANK_W)) u_sva (
  .clk            (clk),
  .rst            (rst),
  .cfg_wr_en      (cfg_wr_en),
  .act_en         (act_en),
  .act_bank       (act_bank),
  .act_sr1        (act_sr1),
  .ref_en         (ref_en),
  .col_en         (col_en),
  .col_bank       (col_bank),
  .col_sc1        (col_sc1),
  .pre_en         (pre_en),
  .pre_all        (pre_all),
  .cfg_width_q    (cfg_width_q),
  .cfg_sub_q      (cfg_sub_q),
  .cfg_err        (cfg_err),
  .sub_viol_valid (sub_viol_valid),
  .no_row_valid   (no_row_valid),
  .viol_bank      (viol_bank)
);

// File: tb/tb_subrow_guard.sv
module tb_subrow_guard;

  localparam int CLK_PERIOD = 10;
  localparam int NB = 8;
  localparam int BW = 3;

  logic clk = 1'b0;
  logic rst;
  logic cfg_wr_en;
  logic [2:0] cfg_width;
  logic [1:0] cfg_sub;
  logic act_en, act_sr1, ref_en, ref_all, col_en, col_sc1, pre_en, pre_all;
  logic [BW-1:0] act_bank, ref_bank, col_bank, pre_bank;
  logic [2:0] cfg_width_q;
  logic [1:0] cfg_sub_q;
  logic cfg_err, sub_viol_valid, no_row_valid;
  logic [BW-1:0] viol_bank;

  always #(CLK_PERIOD/2) clk = ~clk;

  subrow_guard #(.BANKS(NB)) dut (.*);

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // Bench model, built from the requirements.
  int m_w, m_s, m_err, m_bank;
  int m_mode [NB];  // 0 idle, 1 full, 2 half
  int m_sr [NB];

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic bit legal(input int w, input int s);
    if (!(w >= 1 && w <= 4)) return 0;
    if (s == 0) return 1;
    if (s == 1 || s == 2) return (w == 1);
    return 0;
  endfunction

  task automatic idle_inputs();
    cfg_wr_en = 0; cfg_width = 0; cfg_sub = 0;
    act_en = 0; act_bank = 0; act_sr1 = 0;
    ref_en = 0; ref_all = 0; ref_bank = 0;
    col_en = 0; col_bank = 0; col_sc1 = 0;
    pre_en = 0; pre_all = 0; pre_bank = 0;
  endtask

  task automatic do_reset();
    idle_inputs();
    rst = 1;
    @(negedge clk); @(negedge clk);
    rst = 0;
    m_w = 1; m_s = 0; m_err = 0; m_bank = 0;
    for (int b = 0; b < NB; b++) begin m_mode[b] = 0; m_sr[b] = 0; end
    @(negedge clk);
  endtask

  // One cycle of commands; outputs checked after the capturing edge.
  task automatic cyc(input string tag,
                     input bit we, input int w, input int s,
                     input bit ae, input int ab, input bit asr,
                     input bit re, input bit rall, input int rb,
                     input bit ce, input int cb, input bit csc,
                     input bit pe, input bit pall, input int pb);
    int e_sv, e_nr;
    cfg_wr_en = we; cfg_width = 3'(w); cfg_sub = 2'(s);
    act_en = ae; act_bank = BW'(ab); act_sr1 = asr;
    ref_en = re; ref_all = rall; ref_bank = BW'(rb);
    col_en = ce; col_bank = BW'(cb); col_sc1 = csc;
    pre_en = pe; pre_all = pall; pre_bank = BW'(pb);
    e_sv = (ce && m_mode[cb] == 2 && m_sr[cb] != int'(csc)) ? 1 : 0;
    e_nr = (ce && m_mode[cb] == 0) ? 1 : 0;
    if (ce) m_bank = cb;
    for (int b = 0; b < NB; b++) begin
      if (re && (rall || rb == b)) begin m_mode[b] = 1; m_sr[b] = 0; end
      if (ae && ab == b) begin m_mode[b] = (m_s != 0) ? 2 : 1; m_sr[b] = asr; end
      if (pe && (pall || pb == b)) begin m_mode[b] = 0; m_sr[b] = 0; end
    end
    if (we) begin
      if (legal(w, s)) begin m_w = w; m_s = s; end
      else m_err = 1;
    end
    @(negedge clk);
    idle_inputs();
    chk(tag, "sub_viol_valid", int'(sub_viol_valid), e_sv);
    chk(tag, "no_row_valid", int'(no_row_valid), e_nr);
    chk(tag, "viol_bank", int'(viol_bank), m_bank);
    chk(tag, "cfg_width_q", int'(cfg_width_q), m_w);
    chk(tag, "cfg_sub_q", int'(cfg_sub_q), m_s);
    chk(tag, "cfg_err", int'(cfg_err), m_err);
  endtask

  task automatic wr_cfg(input string tag, input int w, input int s);
    cyc(tag, 1, w, s, 0,0,0, 0,0,0, 0,0,0, 0,0,0);
  endtask
  task automatic act(input string tag, input int b, input bit sr);
    cyc(tag, 0,0,0, 1,b,sr, 0,0,0, 0,0,0, 0,0,0);
  endtask
  task automatic col(input string tag, input int b, input bit sc);
    cyc(tag, 0,0,0, 0,0,0, 0,0,0, 1,b,sc, 0,0,0);
  endtask
  task automatic pre(input string tag, input bit all, input int b);
    cyc(tag, 0,0,0, 0,0,0, 0,0,0, 0,0,0, 1,all,b);
  endtask
  task automatic refr(input string tag, input bit all, input int b);
    cyc(tag, 0,0,0, 0,0,0, 1,all,b, 0,0,0, 0,0,0);
  endtask
  task automatic nop(input string tag);
    cyc(tag, 0,0,0, 0,0,0, 0,0,0, 0,0,0, 0,0,0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : stim
    do_reset();
    // R1: reset state, every bank idle
    chk("R1", "cfg_width_q", int'(cfg_width_q), 1);
    chk("R1", "cfg_sub_q", int'(cfg_sub_q), 0);
    chk("R1", "cfg_err", int'(cfg_err), 0);
    chk("R1", "pulses", int'({sub_viol_valid, no_row_valid}), 0);
    for (int b = 0; b < NB; b++) col("R1", b, 0);

    // R2 / R3: every width/sub pair, each landing on the previous result
    for (int w = 0; w < 8; w++)
      for (int s = 0; s < 4; s++) begin
        wr_cfg(legal(w, s) ? "R2" : "R3", w, s);
        // R3: after any write, a half/quarter setting still opens in half mode
        act("R3", 0, 1);
        col("R3", 0, 0);
        pre("R8", 0, 0);
      end
    // R3: sticky across a legal write
    wr_cfg("R3", 1, 0);
    nop("R3");
    do_reset();

    // R4 / R5 / R6: each sub setting, every bank, both SR1 and SC1 values
    for (int s = 0; s < 3; s++) begin
      wr_cfg("R2", 1, s);
      for (int b = 0; b < NB; b++)
        for (int sr = 0; sr < 2; sr++) begin
          act(s == 0 ? "R4" : (s == 1 ? "R5" : "R6"), b, sr[0]);
          for (int sc = 0; sc < 2; sc++)
            col(s == 0 ? "R4" : (s == 1 ? "R5" : "R6"), b, sc[0]);
          nop("R10");
          pre("R8", 0, b);
        end
    end
    // R4: full mode at a wide device
    wr_cfg("R2", 3, 0);
    act("R4", 5, 1);
    col("R4", 5, 0);

    // R7: refresh opens full even in half mode
    do_reset();
    wr_cfg("R2", 1, 2);
    refr("R7", 1, 0);
    for (int b = 0; b < NB; b++) begin col("R7", b, 1); col("R7", b, 0); end
    pre("R8", 1, 0);
    for (int b = 0; b < NB; b++) col("R8", b, 0);
    refr("R7", 0, 3);
    col("R7", 3, 1);
    col("R7", 2, 1);
    // R7: activate in half mode after a refresh replaces the full state
    act("R5", 3, 0);
    col("R5", 3, 1);

    // R11: ordering within one cycle
    pre("R8", 1, 0);
    cyc("R11", 0,0,0, 1,4,1, 0,0,0, 0,0,0, 1,0,4);   // act + pre same bank
    col("R11", 4, 0);
    cyc("R11", 0,0,0, 1,6,1, 0,0,0, 1,6,0, 0,0,0);   // col sees idle, act lands
    col("R11", 6, 0);
    col("R11", 6, 1);
    cyc("R11", 0,0,0, 0,0,0, 1,0,2, 0,0,0, 1,0,2);   // refresh + pre same bank
    col("R11", 2, 0);
    cyc("R11", 1,1,0, 1,7,1, 0,0,0, 0,0,0, 0,0,0);   // cfg write + act: old half mode
    col("R11", 7, 0);
    act("R11", 1, 1);
    col("R11", 1, 0);
    // R10: back-to-back offending columns give one pulse each
    wr_cfg("R2", 1, 1);
    act("R10", 0, 0);
    col("R10", 0, 1);
    col("R10", 0, 1);
    nop("R10");
    col("R10", 5, 0);
    nop("R10");

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule